// File: doc/BRIEF.md
# DisplayPort Link Training Controller

This block trains a DisplayPort main link at a requested rate over one, two or four lanes. It sets the rate and lane count in the sink, then runs clock recovery followed by channel equalisation. Each pass commits a drive setting, waits a fixed number of microseconds, and reads the sink's per-lane status. Between passes it reads the sink's adjust requests and folds them into a single drive level that every lane uses. When training fails at a higher rate, it repeats the whole sequence once at the lowest rate.

All sink accesses go through one generic request port. A request carries a read/write flag, an address, a byte count of one to four, and write data, and it is held until the sink answers with done or error. Timing comes from a free-running one-microsecond tick input. The limits of the drive table are static inputs: a maximum swing, and one maximum pre-emphasis per swing level. The block reports its outcome with a one-cycle `done` pulse, a `pass` level and the rate that was last trained.

Top module: `dp_link_trainer`

## Requirements
- R1: After reset the block is idle. `req_valid`, `busy`, `done` and `pass` are all 0.
- R2: On `start` the block writes the rate code to address 0x100 and then the lane count to address 0x101. Each write is one byte in `req_wdata[7:0]`.
- R3: A training pattern is set by reading one byte at 0x102 and writing it back with bits [1:0] replaced. Pattern 1 is used for clock recovery, 2 for equalisation and 0 for off. The other bits are preserved, and the pattern is always set to 0 before `done`.
- R4: Lane i's status is nibble `rsp_rdata[4i+3:4i]`: bit 0 is clock recovery done, bit 1 is equalisation done and bit 2 is symbol lock. Interlane alignment is `rsp_rdata[16]`. Only lanes below the lane count are evaluated.
- R5: Adjust requests are read as two bytes at 0x206, using the same nibble layout as the status, with swing in bits [1:0] and pre-emphasis in bits [3:2]. The controller takes the maximum of each over the active lanes. The drive byte is pre-emphasis shifted left by 3, ORed with the swing, and it is written as four identical bytes to 0x103.
- R6: A merged swing at or above `max_swing` becomes `max_swing` with bit 2 set. The pre-emphasis is then compared against `max_pre[2s+1:2s]`, where s is the resulting swing. If it reaches that limit it becomes the limit with bit 2 set, which is bit 5 of the drive byte.
- R7: In clock recovery, each drive commit is followed by a wait of 100 ticks and then a two-byte status read at 0x202. The first commit uses drive 0.
- R8: Clock recovery succeeds when every active lane reports recovery done. If any active lane fails while bit 5 of the committed drive byte is set, the phase fails at once.
- R9: Clock recovery fails after 5 status reads at an unchanged swing. The count restarts whenever the committed swing differs from the swing of the previous read.
- R10: Equalisation sets pattern 2 and then runs at most 6 rounds. Each round waits 400 ticks and reads three status bytes at 0x202. It succeeds when alignment is set and every active lane has recovery done, equalisation done and symbol lock.
- R11: In equalisation, lanes are checked in order. The first active lane without recovery done fails the phase. Missing alignment, a missing equalisation bit or a missing symbol-lock bit causes an adjust read and a new commit, unless 6 rounds have been used.
- R12: If training fails with no request error and the rate is not the lowest code 0x06, the rate becomes 0x06 and the sequence restarts from R2. At 0x06 no retry follows.
- R13: A request answered with `rsp_err` ends training: the pattern is set to 0 (unless that access itself failed), `pass` is 0 and no rate fallback happens.
- R14: A request holds its valid, address and data until a response arrives. `done` is a single-cycle pulse, and at that pulse `pass` and `rate_out` give the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| us_tick | input | 1 | One-cycle pulse each microsecond |
| start | input | 1 | Begin training (accepted when idle) |
| rate_in | input | RATE_W | Requested rate code |
| lanes_in | input | 3 | Lane count: 1, 2 or 4 |
| max_swing | input | 2 | Highest swing level in the drive table |
| max_pre | input | 8 | Highest pre-emphasis per swing level, 2 bits each |
| req_valid | output | 1 | Sink access pending |
| req_write | output | 1 | 1 = write, 0 = read |
| req_addr | output | ADDR_W | Sink register address |
| req_len | output | 3 | Byte count, 1 to 4 |
| req_wdata | output | 32 | Write bytes, first byte in bits [7:0] |
| rsp_done | input | 1 | Access completed |
| rsp_err | input | 1 | Access failed |
| rsp_rdata | input | 32 | Read bytes, first byte in bits [7:0] |
| busy | output | 1 | Training in progress |
| done | output | 1 | One-cycle completion pulse |
| pass | output | 1 | Last training succeeded |
| rate_out | output | RATE_W | Rate code of the last attempt |

## Verification
The embedded assertions check the cycle-level rules on every cycle. A request stays stable until it gets a response, `done` lasts a single cycle, a failed run without an error ends at the lowest rate, a committed drive byte with its swing flag set carries exactly the table maximum, and the retry and round counters stay within their limits. Sequence-level properties are visible only in the bench's sink scenarios. These include how many commits each exit path costs, the restart of the try count when the swing changes, lanes beyond the lane count being ignored in both status and adjust data, the wait lengths, the clamped drive byte, and the final value of the pattern register.

// File: rtl/dp_link_trainer.sv
module dp_link_trainer #(
  parameter int ADDR_W = 12,
  parameter int RATE_W = 8,
  parameter logic [RATE_W-1:0] LOW_RATE = 'h06,
  parameter int CR_WAIT_US = 100,
  parameter int EQ_WAIT_US = 400,
  parameter int CR_TRIES = 5,
  parameter int EQ_TRIES = 6,
  parameter logic [ADDR_W-1:0] A_RATE  = 'h100,
  parameter logic [ADDR_W-1:0] A_LANES = 'h101,
  parameter logic [ADDR_W-1:0] A_PAT   = 'h102,
  parameter logic [ADDR_W-1:0] A_DRIVE = 'h103,
  parameter logic [ADDR_W-1:0] A_STAT  = 'h202,
  parameter logic [ADDR_W-1:0] A_ADJ   = 'h206
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              us_tick,
  input  logic              start,
  input  logic [RATE_W-1:0] rate_in,
  input  logic [2:0]        lanes_in,
  input  logic [1:0]        max_swing,
  input  logic [7:0]        max_pre,
  output logic              req_valid,
  output logic              req_write,
  output logic [ADDR_W-1:0] req_addr,
  output logic [2:0]        req_len,
  output logic [31:0]       req_wdata,
  input  logic              rsp_done,
  input  logic              rsp_err,
  input  logic [31:0]       rsp_rdata,
  output logic              busy,
  output logic              done,
  output logic              pass,
  output logic [RATE_W-1:0] rate_out
);

  localparam int WAIT_MAX = (CR_WAIT_US > EQ_WAIT_US) ? CR_WAIT_US : EQ_WAIT_US;
  localparam int WAIT_W   = $clog2(WAIT_MAX + 1);
  localparam int TRY_MAX  = (CR_TRIES > EQ_TRIES) ? CR_TRIES : EQ_TRIES;
  localparam int TRY_W    = $clog2(TRY_MAX + 1);

  typedef enum logic [3:0] {
    ST_IDLE, ST_RATE, ST_LANES, ST_PAT_RD, ST_PAT_WR,
    ST_CR_COMMIT, ST_CR_WAIT, ST_CR_STAT, ST_CR_ADJ,
    ST_EQ_WAIT, ST_EQ_STAT, ST_EQ_ADJ, ST_EQ_COMMIT, ST_FINISH
  } state_t;

  state_t            state;
  logic [RATE_W-1:0] rate_q;
  logic [2:0]        lanes_q;
  logic [7:0]        drive;
  logic [7:0]        pat_byte;
  logic [1:0]        pat_sel;
  logic [1:0]        last_vs;
  logic              vs_known;
  logic [TRY_W-1:0]  cr_tries;
  logic [TRY_W-1:0]  eq_round;
  logic [WAIT_W-1:0] wcnt;
  logic              ok_q;
  logic              abort_q;
  logic              pass_q;

  logic [3:0]        act;
  logic [1:0]        adj_vs, adj_pre, pre_lim;
  logic [2:0]        vs_f, pre_f;
  logic [7:0]        merged;
  logic              cr_all;
  logic              eq_lost, eq_bad, eq_stop;
  logic              swing_new;
  logic [TRY_W-1:0]  tries_nx, round_nx;
  logic              wait_hit;
  logic              unused_rdata;

  assign unused_rdata = ^rsp_rdata[31:17];

  always_comb
    for (int i = 0; i < 4; i++) act[i] = (3'(i) < lanes_q);

  always_comb begin
    adj_vs  = 2'd0;
    adj_pre = 2'd0;
    for (int i = 0; i < 4; i++)
      if (act[i]) begin
        if (rsp_rdata[4*i +: 2] > adj_vs)    adj_vs  = rsp_rdata[4*i +: 2];
        if (rsp_rdata[4*i+2 +: 2] > adj_pre) adj_pre = rsp_rdata[4*i+2 +: 2];
      end
    vs_f    = (adj_vs >= max_swing) ? {1'b1, max_swing} : {1'b0, adj_vs};
    pre_lim = max_pre[2*vs_f[1:0] +: 2];
    pre_f   = (adj_pre >= pre_lim) ? {1'b1, pre_lim} : {1'b0, adj_pre};
    merged  = {2'b00, pre_f, vs_f};
  end

  always_comb begin
    cr_all = 1'b1;
    for (int i = 0; i < 4; i++)
      if (act[i] && !rsp_rdata[4*i]) cr_all = 1'b0;
  end

  always_comb begin
    eq_lost = 1'b0;
    eq_bad  = !rsp_rdata[16];
    eq_stop = eq_bad;
    for (int i = 0; i < 4; i++)
      if (!eq_stop && act[i]) begin
        if (!rsp_rdata[4*i]) begin
          eq_lost = 1'b1;
          eq_stop = 1'b1;
        end else if (!rsp_rdata[4*i+1] || !rsp_rdata[4*i+2]) begin
          eq_bad  = 1'b1;
          eq_stop = 1'b1;
        end
      end
  end

  assign swing_new = !vs_known || (drive[1:0] != last_vs);
  assign tries_nx  = swing_new ? TRY_W'(1) : cr_tries + TRY_W'(1);
  assign round_nx  = eq_round + TRY_W'(1);
  assign wait_hit  = (state == ST_CR_WAIT) ? (wcnt == WAIT_W'(CR_WAIT_US - 1))
                                           : (wcnt == WAIT_W'(EQ_WAIT_US - 1));

  always_comb begin
    req_valid = 1'b1;
    req_write = 1'b0;
    req_addr  = '0;
    req_len   = 3'd1;
    req_wdata = '0;
    case (state)
      ST_RATE:   begin req_write = 1'b1; req_addr = A_RATE;  req_wdata = 32'(rate_q);  end
      ST_LANES:  begin req_write = 1'b1; req_addr = A_LANES; req_wdata = 32'(lanes_q); end
      ST_PAT_RD: req_addr = A_PAT;
      ST_PAT_WR: begin
        req_write = 1'b1;
        req_addr  = A_PAT;
        req_wdata = {24'h0, pat_byte[7:2], pat_sel};
      end
      ST_CR_COMMIT, ST_EQ_COMMIT: begin
        req_write = 1'b1;
        req_addr  = A_DRIVE;
        req_len   = 3'd4;
        req_wdata = {4{drive}};
      end
      ST_CR_STAT: begin req_addr = A_STAT; req_len = 3'd2; end
      ST_EQ_STAT: begin req_addr = A_STAT; req_len = 3'd3; end
      ST_CR_ADJ, ST_EQ_ADJ: begin req_addr = A_ADJ; req_len = 3'd2; end
      default: req_valid = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      rate_q   <= '0;
      lanes_q  <= '0;
      drive    <= '0;
      pat_byte <= '0;
      pat_sel  <= '0;
      last_vs  <= '0;
      vs_known <= 1'b0;
      cr_tries <= '0;
      eq_round <= '0;
      wcnt     <= '0;
      ok_q     <= 1'b0;
      abort_q  <= 1'b0;
      pass_q   <= 1'b0;
    end else begin
      case (state)
        ST_IDLE:
          if (start) begin
            rate_q  <= rate_in;
            lanes_q <= lanes_in;
            ok_q    <= 1'b0;
            abort_q <= 1'b0;
            pass_q  <= 1'b0;
            state   <= ST_RATE;
          end
        ST_CR_WAIT, ST_EQ_WAIT:
          if (us_tick) begin
            if (wait_hit) begin
              wcnt  <= '0;
              state <= (state == ST_CR_WAIT) ? ST_CR_STAT : ST_EQ_STAT;
            end else begin
              wcnt <= wcnt + WAIT_W'(1);
            end
          end
        ST_FINISH: state <= ST_IDLE;
        default:
          if (rsp_err) begin
            abort_q <= 1'b1;
            if ((state == ST_PAT_RD || state == ST_PAT_WR) && pat_sel == 2'd0) begin
              pass_q <= 1'b0;
              state  <= ST_FINISH;
            end else begin
              pat_sel <= 2'd0;
              state   <= ST_PAT_RD;
            end
          end else if (rsp_done) begin
            case (state)
              ST_RATE:  state <= ST_LANES;
              ST_LANES: begin pat_sel <= 2'd1; state <= ST_PAT_RD; end
              ST_PAT_RD: begin pat_byte <= rsp_rdata[7:0]; state <= ST_PAT_WR; end
              ST_PAT_WR:
                case (pat_sel)
                  2'd1: begin
                    drive    <= '0;
                    vs_known <= 1'b0;
                    cr_tries <= '0;
                    state    <= ST_CR_COMMIT;
                  end
                  2'd2: begin
                    eq_round <= '0;
                    wcnt     <= '0;
                    state    <= ST_EQ_WAIT;
                  end
                  default:
                    if (!ok_q && !abort_q && rate_q != LOW_RATE) begin
                      rate_q <= LOW_RATE;
                      state  <= ST_RATE;
                    end else begin
                      pass_q <= ok_q && !abort_q;
                      state  <= ST_FINISH;
                    end
                endcase
              ST_CR_COMMIT: begin wcnt <= '0; state <= ST_CR_WAIT; end
              ST_CR_STAT: begin
                last_vs  <= drive[1:0];
                vs_known <= 1'b1;
                cr_tries <= tries_nx;
                if (cr_all) begin
                  pat_sel <= 2'd2;
                  state   <= ST_PAT_RD;
                end else if (drive[5] || tries_nx == TRY_W'(CR_TRIES)) begin
                  pat_sel <= 2'd0;
                  state   <= ST_PAT_RD;
                end else begin
                  state <= ST_CR_ADJ;
                end
              end
              ST_CR_ADJ: begin drive <= merged; state <= ST_CR_COMMIT; end
              ST_EQ_STAT: begin
                eq_round <= round_nx;
                if (!eq_lost && !eq_bad) begin
                  ok_q    <= 1'b1;
                  pat_sel <= 2'd0;
                  state   <= ST_PAT_RD;
                end else if (eq_lost || round_nx == TRY_W'(EQ_TRIES)) begin
                  pat_sel <= 2'd0;
                  state   <= ST_PAT_RD;
                end else begin
                  state <= ST_EQ_ADJ;
                end
              end
              ST_EQ_ADJ:    begin drive <= merged; state <= ST_EQ_COMMIT; end
              ST_EQ_COMMIT: begin wcnt <= '0; state <= ST_EQ_WAIT; end
              default: ;
            endcase
          end
      endcase
    end
  end

  assign busy     = (state != ST_IDLE);
  assign done     = (state == ST_FINISH);
  assign pass     = pass_q;
  assign rate_out = rate_q;

  // R14
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !rsp_done && !rsp_err) |=>
      (req_valid && $stable(req_addr) && $stable(req_wdata) && $stable(req_write)));

  // R14
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R12
  fallback_rate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !pass && !abort_q) |-> (rate_out == LOW_RATE));

  // R13
  abort_fail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && abort_q) |-> !pass);

  // R6
  swing_clamp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && req_addr == A_DRIVE && req_wdata[2]) |->
      (req_wdata[1:0] == max_swing));

  // R9
  cr_tries_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cr_tries <= TRY_W'(CR_TRIES));

  // R10
  eq_round_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eq_round <= TRY_W'(EQ_TRIES));

endmodule

// File: tb/test_dp_link_trainer.sv
module test_dp_link_trainer;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        us_tick = 1'b0;
  logic        start = 1'b0;
  logic [7:0]  rate_in = 8'h0A;
  logic [2:0]  lanes_in = 3'd4;
  logic [1:0]  max_swing = 2'd3;
  logic [7:0]  max_pre = 8'h1B;
  logic        req_valid, req_write;
  logic [11:0] req_addr;
  logic [2:0]  req_len;
  logic [31:0] req_wdata;
  logic        rsp_done = 1'b0, rsp_err = 1'b0;
  logic [31:0] rsp_rdata = '0;
  logic        busy, done, pass;
  logic [7:0]  rate_out;

  dp_link_trainer i_dp_link_trainer (
    .clk(clk), .rst_n(rst_n), .us_tick(us_tick), .start(start),
    .rate_in(rate_in), .lanes_in(lanes_in), .max_swing(max_swing), .max_pre(max_pre),
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
    .req_len(req_len), .req_wdata(req_wdata),
    .rsp_done(rsp_done), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
    .busy(busy), .done(done), .pass(pass), .rate_out(rate_out)
  );

  always #2 clk = ~clk;

  int n_chk = 0, n_bad = 0;
  int tick_cnt = 0, mark = 0;

  // sink model state and scenario knobs
  logic [7:0]  rate_reg, lanes_reg, pat_reg;
  logic [31:0] drive_word;
  int          n_commit, n_eq_rd, n_rate_wr;
  logic        seen_p1, seen_p2;
  logic [1:0]  need_vs;
  logic        cr_never, eq_cr_lost, align_ok;
  logic [3:0]  cr_bad, eq_bad;
  logic [15:0] adj_word;
  logic [11:0] err_addr;

  localparam logic [7:0] PAT_BASE = 8'hB4;

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  initial begin
    forever begin
      repeat (4) @(negedge clk);
      us_tick = 1'b1;
      tick_cnt++;
      @(negedge clk);
      us_tick = 1'b0;
    end
  end

  task automatic serve();
    logic [31:0] rd;
    int delta;
    rd = '0;
    if (req_addr == err_addr) begin
      rsp_err = 1'b1;
    end else begin
      if (req_write) begin
        case (req_addr)
          12'h100: begin rate_reg = req_wdata[7:0]; n_rate_wr++; end
          12'h101: lanes_reg = req_wdata[7:0];
          12'h102: begin
            pat_reg = req_wdata[7:0];
            mark = tick_cnt;
            if (req_wdata[7:0] == (PAT_BASE | 8'h01)) seen_p1 = 1'b1;
            if (req_wdata[7:0] == (PAT_BASE | 8'h02)) seen_p2 = 1'b1;
          end
          12'h103: begin drive_word = req_wdata; n_commit++; mark = tick_cnt; end
          default: ;
        endcase
      end else begin
        case (req_addr)
          12'h102: rd = {24'h0, pat_reg};
          12'h202: begin
            delta = tick_cnt - mark;
            n_chk++;
            if (req_len == 3'd3) begin
              n_eq_rd++;
              if (delta < 400 || delta > 402) begin
                n_bad++;
                $display("FAIL R10: eq wait got %0d expected 400", delta);
              end
            end else if (delta < 100 || delta > 102) begin
              n_bad++;
              $display("FAIL R7: cr wait got %0d expected 100", delta);
            end
            for (int i = 0; i < 4; i++) begin
              rd[4*i]   = !cr_never && (drive_word[1:0] >= need_vs) && !cr_bad[i]
                          && !(eq_cr_lost && pat_reg[1:0] == 2'd2);
              rd[4*i+1] = !eq_bad[i];
              rd[4*i+2] = !eq_bad[i];
            end
            rd[16] = align_ok;
          end
          12'h206: rd = {16'h0, adj_word};
          default: ;
        endcase
      end
      rsp_done = 1'b1;
    end
    rsp_rdata = rd;
  endtask

  initial begin
    forever begin
      @(negedge clk);
      if (req_valid) begin
        repeat (2) @(negedge clk);
        serve();
        @(negedge clk);
        rsp_done = 1'b0;
        rsp_err  = 1'b0;
      end
    end
  end

  task automatic defaults();
    need_vs = 2'd0; cr_never = 1'b0; eq_cr_lost = 1'b0; align_ok = 1'b1;
    cr_bad = 4'h0; eq_bad = 4'h0; adj_word = 16'h0; err_addr = 12'hFFF;
    max_swing = 2'd3; max_pre = 8'h1B;
  endtask

  task automatic run(input logic [7:0] r, input logic [2:0] ln);
    rate_in = r; lanes_in = ln;
    rate_reg = 8'h00; lanes_reg = 8'h00; pat_reg = PAT_BASE; drive_word = '0;
    n_commit = 0; n_eq_rd = 0; n_rate_wr = 0; seen_p1 = 1'b0; seen_p2 = 1'b0;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    while (!done) @(negedge clk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got hang expected finish");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    defaults();
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 req_valid", req_valid, 0);
    check("R1 busy", busy, 0);
    check("R1 done", done, 0);
    check("R1 pass", pass, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // all lanes good at once
    defaults();
    run(8'h0A, 3'd4);
    check("R14 pass", pass, 1);
    check("R14 rate_out", rate_out, 8'h0A);
    check("R2 rate written", rate_reg, 8'h0A);
    check("R2 lanes written", lanes_reg, 4);
    check("R7 single commit", n_commit, 1);
    check("R3 pattern 1 rmw", seen_p1, 1);
    check("R3 pattern 2 rmw", seen_p2, 1);
    check("R3 pattern off, bits kept", pat_reg, PAT_BASE);
    check("R10 one eq round", n_eq_rd, 1);

    // recovery never done, no adjust: 5 tries then fallback
    defaults(); cr_never = 1'b1;
    run(8'h0A, 3'd4);
    check("R9 five tries per rate", n_commit, 10);
    check("R12 fallback rate", rate_out, 8'h06);
    check("R12 rate written twice", n_rate_wr, 2);
    check("R12 fail", pass, 0);

    // merged swing from an odd lane
    defaults(); need_vs = 2'd2; adj_word = 16'h0020;
    run(8'h0A, 3'd4);
    check("R5 merged drive word", drive_word, 32'h02020202);
    check("R5 commits", n_commit, 2);
    check("R5 pass", pass, 1);

    // swing change restarts the try count; already lowest rate
    defaults(); need_vs = 2'd2; adj_word = 16'h0001;
    run(8'h06, 3'd4);
    check("R9 try count restart", n_commit, 6);
    check("R12 no retry at lowest", n_rate_wr, 1);
    check("R12 rate", rate_out, 8'h06);

    // clamping and max-reached exit
    defaults(); max_swing = 2'd2; cr_never = 1'b1; adj_word = 16'h0F00;
    run(8'h0A, 3'd4);
    check("R6 clamped drive", drive_word, 32'h2E2E2E2E);
    check("R8 max flag exit", n_commit, 4);
    check("R8 fail", pass, 0);

    // symbol lock missing on lane 3
    defaults(); eq_bad = 4'b1000;
    run(8'h06, 3'd4);
    check("R10 six rounds", n_eq_rd, 6);
    check("R11 adjust commits", n_commit, 6);
    check("R10 fail", pass, 0);

    // recovery lost during equalisation
    defaults(); eq_cr_lost = 1'b1;
    run(8'h0A, 3'd4);
    check("R11 lost ends phase", n_eq_rd, 2);
    check("R11 commits", n_commit, 2);
    check("R12 rate", rate_out, 8'h06);
    check("R3 pattern off", pat_reg, PAT_BASE);

    // alignment missing
    defaults(); align_ok = 1'b0;
    run(8'h06, 3'd4);
    check("R10 align needed", n_eq_rd, 6);
    check("R11 align adjusts", n_commit, 6);

    // two lanes: upper lanes ignored in status and adjust
    defaults(); need_vs = 2'd1; cr_bad = 4'b1100; eq_bad = 4'b1100; adj_word = 16'hF010;
    run(8'h0A, 3'd2);
    check("R4 inactive lanes ignored", pass, 1);
    check("R5 inactive adjust ignored", drive_word, 32'h01010101);
    check("R2 lane count", lanes_reg, 2);

    // error on status read
    defaults(); err_addr = 12'h202;
    run(8'h0A, 3'd4);
    check("R13 fail", pass, 0);
    check("R13 no fallback", rate_out, 8'h0A);
    check("R13 single rate write", n_rate_wr, 1);
    check("R13 pattern off", pat_reg, PAT_BASE);

    // recovers cleanly after an error
    defaults();
    run(8'h0A, 3'd1);
    check("R14 pass after error", pass, 1);

    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule